// File: doc/BRIEF.md
# Special-Purpose Register Bank with Write Side-Effects

This block holds the special-purpose registers of a small 32-bit processor. A 16-bit register number selects the target. Writes arrive on a move-to port (`mt_en`, `mt_addr`, `mt_data`) and take effect at the rising clock edge. Reads leave on a combinational move-from port (`mf_addr` to `mf_data`).

Many register numbers do more than store a value. Cache command registers clear themselves after a write, except the data-cache flush register, which reads back as all ones. Every cache command is sent out as a one-cycle strobe with an operation code and the written value. The data-cache and instruction-cache invalidating commands also raise their own invalidate strobes. The status register always keeps its fixed-one bit set. A write to the next-PC register produces a one-cycle redirect carrying the new PC and the next fetch address. Reading the next-PC register returns the pipeline's current PC.

Two windows hold data-TLB and instruction-TLB entries. Each entry is masked before it is stored. A 32-register window aliases the general-purpose registers.

Top module: `spr_bank`

## Requirements
- R1: After synchronous reset, the status register (0x0011) reads 0x0000_8000, with only the fixed-one bit 15 set. The aliased GPRs, the TLB entries and the data-cache flush register (0x1802) all read zero.
- R2: Register numbers 0x0400 to 0x041F read and write general-purpose registers 0 to 31. Number 0x0420 is outside the window.
- R3: After any write to the data-cache flush register 0x1802, that register reads 0xFFFF_FFFF.
- R4: After a write, the command registers 0x1801 (data prefetch), 0x1803 (data invalidate), 0x1804 (data write-back), 0x1805 (data lock), 0x2001 (instruction prefetch), 0x2002 (instruction invalidate) and 0x2003 (instruction lock) read zero.
- R5: A write to a command register sets `cache_op_valid` for exactly the next cycle. In that cycle `cache_op` carries the code, and `cache_op_arg` carries the written value. The codes are 0x1801→0, 0x1802→1, 0x1803→2, 0x1804→3, 0x1805→4, 0x2001→5, 0x2002→6, 0x2003→7. A write to 0x1802 or 0x1803 also raises `dc_inval` in that cycle. A write to 0x2002 also raises `ic_inval` in that cycle.
- R6: Every write to the status register stores the written value with bit 15 forced to 1.
- R7: A write to the next-PC register 0x0010 raises `redir_valid` for the next cycle. In that cycle `redir_pc` equals the written value and `redir_fetch` equals the written value plus 4.
- R8: Reading 0x0010 returns the `cur_pc` input.
- R9: The TLB windows are decoded as follows. Bits [15:11] select the TLB: 1 is data, 2 is instruction. Bits [10:8] select the way, with way w at 2+w. Bit 7 selects the entry kind: 0 is match, 1 is translate. Bits [6:0] select the set. A match entry is stored with bits [12:8] cleared (page number rounded down to the 8 KiB default page) and bits [7:0] (valid, PL1, context ID, LRU) kept.
- R10: A translate entry keeps the page number (bits 31:13) plus flag bits [9:0] in the data TLB, or flag bits [7:0] in the instruction TLB. All other bits are stored as zero.
- R11: The following have no visible effect: writes with `mt_en` low, writes to unmapped numbers, and writes to TLB sets at or beyond the set count. Unmapped numbers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mt_en | input | 1 | Write enable of the move-to port |
| mt_addr | input | 16 | Register number to write |
| mt_data | input | 32 | Value to write |
| mf_addr | input | 16 | Register number to read |
| mf_data | output | 32 | Read value (combinational) |
| cur_pc | input | 32 | Current program counter from the pipeline |
| redir_valid | output | 1 | One-cycle PC redirect pulse |
| redir_pc | output | 32 | New program counter |
| redir_fetch | output | 32 | Next fetch address (new PC plus 4) |
| cache_op_valid | output | 1 | One-cycle cache command strobe |
| cache_op | output | 3 | Cache command code |
| cache_op_arg | output | 32 | Value written with the command |
| dc_inval | output | 1 | Data-cache invalidate strobe |
| ic_inval | output | 1 | Instruction-cache invalidate strobe |

## Verification
The bench compares the model and the design every cycle over several write patterns.
- **Self-clearing commands:** a write to each command register separates the flush register's all-ones readback from the zero readback of the others, and shows which of the three commands raise an invalidate strobe.
- **Status register:** values with bit 15 clear and set show that bit 15 is forced and that the other bits are stored.
- **TLB entries:** all-ones values written to match and translate entries of both TLBs, in first and last ways, expose each mask separately.
- **Boundaries and ignored writes:** the two ends of the GPR window, the number just past it, an out-of-range TLB set and writes with the enable low show the window bounds and the ignored writes.

// File: rtl/spr_pkg.sv
package spr_pkg;
   localparam int XLEN = 32;
   localparam int AW   = 16;

   localparam logic [AW-1:0] A_NPC    = 16'h0010;
   localparam logic [AW-1:0] A_STAT   = 16'h0011;
   localparam logic [AW-1:0] A_GPR0   = 16'h0400;
   localparam logic [AW-1:0] A_DPREF  = 16'h1801;
   localparam logic [AW-1:0] A_DFLUSH = 16'h1802;
   localparam logic [AW-1:0] A_DINV   = 16'h1803;
   localparam logic [AW-1:0] A_DWB    = 16'h1804;
   localparam logic [AW-1:0] A_DLOCK  = 16'h1805;
   localparam logic [AW-1:0] A_IPREF  = 16'h2001;
   localparam logic [AW-1:0] A_IINV   = 16'h2002;
   localparam logic [AW-1:0] A_ILOCK  = 16'h2003;

   localparam logic [4:0] GRP_DTLB = 5'd1;
   localparam logic [4:0] GRP_ITLB = 5'd2;

   typedef enum logic [2:0] {
      CO_DPREF  = 3'd0,
      CO_DFLUSH = 3'd1,
      CO_DINV   = 3'd2,
      CO_DWB    = 3'd3,
      CO_DLOCK  = 3'd4,
      CO_IPREF  = 3'd5,
      CO_IINV   = 3'd6,
      CO_ILOCK  = 3'd7
   } cache_op_e;
endpackage

// File: rtl/spr_gpr_file.sv
module spr_gpr_file #(
   parameter int NREG = 32,
   parameter int DW   = 32,
   parameter logic [15:0] BASE = 16'h0400
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [15:0]   waddr,
   input  logic [DW-1:0] wdata,
   input  logic [15:0]   raddr,
   output logic          rhit,
   output logic [DW-1:0] rdata
);
   localparam int IW = $clog2(NREG);

   generate
      if ((1 << IW) != NREG || (BASE & 16'((1 << IW) - 1)) != 16'd0) begin : g_bad_cfg
         $error("spr_gpr_file: NREG must be a power of two and BASE aligned to it");
      end
   endgenerate

   logic [DW-1:0] regs [NREG];
   logic          whit;

   assign whit = (waddr[15:IW] == BASE[15:IW]);
   assign rhit = (raddr[15:IW] == BASE[15:IW]);

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (we && whit) begin
         regs[waddr[IW-1:0]] <= wdata;
      end
   end

   assign rdata = rhit ? regs[raddr[IW-1:0]] : '0;
endmodule

// File: rtl/spr_tlb_bank.sv
module spr_tlb_bank #(
   parameter int          WAYS      = 4,
   parameter int          SETS      = 16,
   parameter int          PAGE_BITS = 13,
   parameter logic [4:0]  GROUP     = 5'd1,
   parameter logic [31:0] MR_FLAGS  = 32'h0000_00FF,
   parameter logic [31:0] TR_FLAGS  = 32'h0000_03FF
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        we,
   input  logic [15:0] waddr,
   input  logic [31:0] wdata,
   input  logic [15:0] raddr,
   output logic        rhit,
   output logic [31:0] rdata
);
   localparam int          WAY_BASE  = 2;
   localparam int          ENTRIES   = WAYS * SETS;
   localparam int          IDX_W     = $clog2(2 * ENTRIES);
   localparam logic [31:0] PAGE_MASK = ~((32'd1 << PAGE_BITS) - 32'd1);
   localparam logic [31:0] MR_KEEP   = PAGE_MASK | MR_FLAGS;
   localparam logic [31:0] TR_KEEP   = PAGE_MASK | TR_FLAGS;

   generate
      if (WAYS < 1 || WAYS > 8 - WAY_BASE) begin : g_bad_ways
         $error("spr_tlb_bank: WAYS out of range");
      end
      if (SETS < 1 || SETS > 128) begin : g_bad_sets
         $error("spr_tlb_bank: SETS out of range");
      end
      if (PAGE_BITS < 10 || PAGE_BITS > 31) begin : g_bad_page
         $error("spr_tlb_bank: page field would overlap flag bits");
      end
   endgenerate

   function automatic logic in_window(input logic [15:0] a);
      return (a[15:11] == GROUP) && (int'(a[10:8]) >= WAY_BASE) &&
             (int'(a[10:8]) < WAY_BASE + WAYS) && (int'(a[6:0]) < SETS);
   endfunction

   function automatic logic [IDX_W-1:0] slot_of(input logic [15:0] a);
      int s;
      s = (a[7] ? ENTRIES : 0) + (int'(a[10:8]) - WAY_BASE) * SETS + int'(a[6:0]);
      return IDX_W'(s);
   endfunction

   logic [31:0] ent [2*ENTRIES];
   logic [31:0] kept;

   assign kept = wdata & (waddr[7] ? TR_KEEP : MR_KEEP);

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 2 * ENTRIES; i++) ent[i] <= '0;
      end else if (we && in_window(waddr)) begin
         ent[slot_of(waddr)] <= kept;
      end
   end

   assign rhit  = in_window(raddr);
   assign rdata = rhit ? ent[slot_of(raddr)] : '0;
endmodule

// File: rtl/spr_cache_cmd.sv
module spr_cache_cmd
   import spr_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        we,
   input  logic [15:0] waddr,
   input  logic [31:0] wdata,
   input  logic [15:0] raddr,
   output logic        rhit,
   output logic [31:0] rdata,
   output logic        op_valid,
   output logic [2:0]  op,
   output logic [31:0] op_arg,
   output logic        dinv,
   output logic        iinv
);
   logic      w_cmd;
   cache_op_e w_code;
   logic      flush_seen;

   always_comb begin
      w_cmd  = 1'b1;
      w_code = CO_DPREF;
      unique case (waddr)
         A_DPREF:  w_code = CO_DPREF;
         A_DFLUSH: w_code = CO_DFLUSH;
         A_DINV:   w_code = CO_DINV;
         A_DWB:    w_code = CO_DWB;
         A_DLOCK:  w_code = CO_DLOCK;
         A_IPREF:  w_code = CO_IPREF;
         A_IINV:   w_code = CO_IINV;
         A_ILOCK:  w_code = CO_ILOCK;
         default:  w_cmd  = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flush_seen <= 1'b0;
         op_valid   <= 1'b0;
         op         <= '0;
         op_arg     <= '0;
         dinv       <= 1'b0;
         iinv       <= 1'b0;
      end else begin
         op_valid <= we && w_cmd;
         dinv     <= we && w_cmd && (w_code == CO_DFLUSH || w_code == CO_DINV);
         iinv     <= we && w_cmd && (w_code == CO_IINV);
         if (we && w_cmd) begin
            op     <= w_code;
            op_arg <= wdata;
         end
         if (we && w_cmd && w_code == CO_DFLUSH) flush_seen <= 1'b1;
      end
   end

   assign rhit  = (raddr >= A_DPREF && raddr <= A_DLOCK) ||
                  (raddr >= A_IPREF && raddr <= A_ILOCK);
   assign rdata = (raddr == A_DFLUSH && flush_seen) ? '1 : '0;
endmodule

// File: rtl/spr_bank.sv
module spr_bank
   import spr_pkg::*;
#(
   parameter int PAGE_BYTES = 8192,
   parameter int TLB_WAYS   = 4,
   parameter int TLB_SETS   = 16,
   parameter int NGPR       = 32,
   parameter int FO_BIT     = 15
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        mt_en,
   input  logic [15:0] mt_addr,
   input  logic [31:0] mt_data,
   input  logic [15:0] mf_addr,
   output logic [31:0] mf_data,
   input  logic [31:0] cur_pc,
   output logic        redir_valid,
   output logic [31:0] redir_pc,
   output logic [31:0] redir_fetch,
   output logic        cache_op_valid,
   output logic [2:0]  cache_op,
   output logic [31:0] cache_op_arg,
   output logic        dc_inval,
   output logic        ic_inval
);
   localparam int          PAGE_BITS = $clog2(PAGE_BYTES);
   localparam logic [31:0] FO_MASK   = 32'd1 << FO_BIT;
   localparam logic [31:0] FETCH_STEP = 32'd4;

   generate
      if ((1 << PAGE_BITS) != PAGE_BYTES) begin : g_bad_page
         $error("spr_bank: PAGE_BYTES must be a power of two");
      end
      if (FO_BIT < 0 || FO_BIT >= XLEN) begin : g_bad_fo
         $error("spr_bank: FO_BIT out of range");
      end
   endgenerate

   logic [31:0] stat_q;
   logic        gpr_hit, cmd_hit, dtlb_hit, itlb_hit;
   logic [31:0] gpr_rd, cmd_rd, dtlb_rd, itlb_rd;

   always_ff @(posedge clk) begin
      if (rst) begin
         stat_q      <= FO_MASK;
         redir_valid <= 1'b0;
         redir_pc    <= '0;
         redir_fetch <= '0;
      end else begin
         if (mt_en && mt_addr == A_STAT) stat_q <= mt_data | FO_MASK;
         redir_valid <= mt_en && (mt_addr == A_NPC);
         if (mt_en && mt_addr == A_NPC) begin
            redir_pc    <= mt_data;
            redir_fetch <= mt_data + FETCH_STEP;
         end
      end
   end

   spr_gpr_file #(.NREG(NGPR), .DW(XLEN), .BASE(A_GPR0)) u_gpr (
      .clk(clk), .rst(rst), .we(mt_en), .waddr(mt_addr), .wdata(mt_data),
      .raddr(mf_addr), .rhit(gpr_hit), .rdata(gpr_rd)
   );

   spr_cache_cmd u_cmd (
      .clk(clk), .rst(rst), .we(mt_en), .waddr(mt_addr), .wdata(mt_data),
      .raddr(mf_addr), .rhit(cmd_hit), .rdata(cmd_rd),
      .op_valid(cache_op_valid), .op(cache_op), .op_arg(cache_op_arg),
      .dinv(dc_inval), .iinv(ic_inval)
   );

   spr_tlb_bank #(
      .WAYS(TLB_WAYS), .SETS(TLB_SETS), .PAGE_BITS(PAGE_BITS), .GROUP(GRP_DTLB),
      .MR_FLAGS(32'h0000_00FF), .TR_FLAGS(32'h0000_03FF)
   ) u_dtlb (
      .clk(clk), .rst(rst), .we(mt_en), .waddr(mt_addr), .wdata(mt_data),
      .raddr(mf_addr), .rhit(dtlb_hit), .rdata(dtlb_rd)
   );

   spr_tlb_bank #(
      .WAYS(TLB_WAYS), .SETS(TLB_SETS), .PAGE_BITS(PAGE_BITS), .GROUP(GRP_ITLB),
      .MR_FLAGS(32'h0000_00FF), .TR_FLAGS(32'h0000_00FF)
   ) u_itlb (
      .clk(clk), .rst(rst), .we(mt_en), .waddr(mt_addr), .wdata(mt_data),
      .raddr(mf_addr), .rhit(itlb_hit), .rdata(itlb_rd)
   );

   always_comb begin
      if (mf_addr == A_NPC)       mf_data = cur_pc;
      else if (mf_addr == A_STAT) mf_data = stat_q;
      else if (gpr_hit)           mf_data = gpr_rd;
      else if (cmd_hit)           mf_data = cmd_rd;
      else if (dtlb_hit)          mf_data = dtlb_rd;
      else if (itlb_hit)          mf_data = itlb_rd;
      else                        mf_data = '0;
   end
endmodule

// File: rtl/spr_bank_chk.sv
module spr_bank_chk (
   input logic        clk,
   input logic        rst,
   input logic        mt_en,
   input logic [15:0] mt_addr,
   input logic [31:0] mt_data,
   input logic [15:0] mf_addr,
   input logic [31:0] mf_data,
   input logic [31:0] cur_pc,
   input logic        redir_valid,
   input logic [31:0] redir_pc,
   input logic [31:0] redir_fetch,
   input logic        cache_op_valid,
   input logic [2:0]  cache_op,
   input logic [31:0] cache_op_arg,
   input logic        dc_inval,
   input logic        ic_inval
);
   a_r3_flush_ones: assert property (@(posedge clk) disable iff (rst)
      (mt_en && mt_addr == 16'h1802) |=> (mf_addr != 16'h1802 || mf_data == 32'hFFFF_FFFF));

   a_r5_dinv_source: assert property (@(posedge clk) disable iff (rst)
      dc_inval |-> $past(mt_en && (mt_addr == 16'h1802 || mt_addr == 16'h1803)));

   a_r5_iinv_source: assert property (@(posedge clk) disable iff (rst)
      ic_inval |-> $past(mt_en && mt_addr == 16'h2002));

   a_r5_op_arg: assert property (@(posedge clk) disable iff (rst)
      (mt_en && mt_addr >= 16'h1801 && mt_addr <= 16'h1805) |=>
         (cache_op_valid && cache_op_arg == $past(mt_data)));

   a_r6_fixed_one: assert property (@(posedge clk) disable iff (rst)
      (mf_addr == 16'h0011) |-> mf_data[15]);

   a_r7_redirect: assert property (@(posedge clk) disable iff (rst)
      (mt_en && mt_addr == 16'h0010) |=>
         (redir_valid && redir_pc == $past(mt_data) && redir_fetch == $past(mt_data) + 32'd4));

   a_r8_npc_read: assert property (@(posedge clk) disable iff (rst)
      (mf_addr == 16'h0010) |-> (mf_data == cur_pc));
endmodule

bind spr_bank spr_bank_chk u_chk (.*);

// File: tb/spr_bank_bench.sv
`timescale 1ns/1ps
module spr_bank_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mt_en = 1'b0;
   logic [15:0] mt_addr = '0;
   logic [31:0] mt_data = '0;
   logic [15:0] mf_addr = '0;
   logic [31:0] cur_pc = 32'h0000_2000;
   logic [31:0] mf_data, redir_pc, redir_fetch, cache_op_arg;
   logic        redir_valid, cache_op_valid, dc_inval, ic_inval;
   logic [2:0]  cache_op;

   int n_chk = 0;
   int n_err = 0;

   // reference state
   logic [31:0] m_gpr [32];
   logic [31:0] m_stat;
   logic        m_flush;
   logic [31:0] m_tlb [logic [15:0]];
   logic        e_redir, e_cop, e_dinv, e_iinv;
   logic [31:0] e_rpc, e_arg;
   logic [2:0]  e_op;

   always #5 clk = ~clk;

   spr_bank u_spr_bank (.*);

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input logic [15:0] a);
      if (a == 16'h0010) return cur_pc;
      if (a == 16'h0011) return m_stat;
      if (a >= 16'h0400 && a < 16'h0420) return m_gpr[a - 16'h0400];
      if (a == 16'h1802) return m_flush ? 32'hFFFF_FFFF : 32'h0;
      if (m_tlb.exists(a)) return m_tlb[a];
      return 32'h0;
   endfunction

   task automatic m_write(input logic [15:0] a, input logic [31:0] d);
      int grp, way, set;
      grp = int'(a >> 11);
      way = int'((a >> 8) & 16'h7) - 2;
      set = int'(a & 16'h7F);
      if (a == 16'h0010) begin
         e_redir = 1'b1; e_rpc = d;
      end
      if (a == 16'h0011) m_stat = d | 32'h0000_8000;
      if (a >= 16'h0400 && a < 16'h0420) m_gpr[a - 16'h0400] = d;
      if (a >= 16'h1801 && a <= 16'h1805) begin
         e_cop = 1'b1; e_op = 3'(a - 16'h1801); e_arg = d;
      end
      if (a >= 16'h2001 && a <= 16'h2003) begin
         e_cop = 1'b1; e_op = 3'(a - 16'h2001 + 5); e_arg = d;
      end
      if (a == 16'h1802) m_flush = 1'b1;
      if (a == 16'h1802 || a == 16'h1803) e_dinv = 1'b1;
      if (a == 16'h2002) e_iinv = 1'b1;
      if ((grp == 1 || grp == 2) && way >= 0 && way < 4 && set < 16) begin
         if (!a[7])          m_tlb[a] = d & 32'hFFFF_E0FF;
         else if (grp == 1)  m_tlb[a] = d & 32'hFFFF_E3FF;
         else                m_tlb[a] = d & 32'hFFFF_E0FF;
      end
   endtask

   // one clock: drive, update the model at the edge, compare everything
   task automatic step(input logic we, input logic [15:0] wa, input logic [31:0] wd,
                       input logic [15:0] ra, input string tag);
      @(negedge clk);
      mt_en = we; mt_addr = wa; mt_data = wd; mf_addr = ra;
      @(posedge clk);
      #1;
      e_redir = 0; e_cop = 0; e_dinv = 0; e_iinv = 0;
      if (we) m_write(wa, wd);
      chk(tag, "read", mf_data, m_read(ra));
      chk(tag, "redir_valid", {31'b0, redir_valid}, {31'b0, e_redir});
      if (e_redir) begin
         chk(tag, "redir_pc", redir_pc, e_rpc);
         chk(tag, "redir_fetch", redir_fetch, e_rpc + 32'd4);
      end
      chk(tag, "cache_op_valid", {31'b0, cache_op_valid}, {31'b0, e_cop});
      if (e_cop) begin
         chk(tag, "cache_op", {29'b0, cache_op}, {29'b0, e_op});
         chk(tag, "cache_op_arg", cache_op_arg, e_arg);
      end
      chk(tag, "dc_inval", {31'b0, dc_inval}, {31'b0, e_dinv});
      chk(tag, "ic_inval", {31'b0, ic_inval}, {31'b0, e_iinv});
   endtask

   initial begin
      #2_000_000;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) m_gpr[i] = '0;
      m_stat = 32'h0000_8000;
      m_flush = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      step(0, 16'h0, 32'h0, 16'h0011, "R1");
      step(0, 16'h0, 32'h0, 16'h0405, "R1");
      step(0, 16'h0, 32'h0, 16'h1802, "R1");
      step(0, 16'h0, 32'h0, 16'h0A03, "R1");
      // R8 next-PC read follows cur_pc
      step(0, 16'h0, 32'h0, 16'h0010, "R8");
      cur_pc = 32'h0000_4A10;
      step(0, 16'h0, 32'h0, 16'h0010, "R8");
      // R2 GPR window ends, R11 just beyond
      step(1, 16'h0400, 32'hCAFE_0001, 16'h0400, "R2");
      step(1, 16'h041F, 32'h1234_5678, 16'h041F, "R2");
      step(0, 16'h0, 32'h0, 16'h0400, "R2");
      step(1, 16'h0420, 32'hDEAD_BEEF, 16'h0420, "R11");
      step(0, 16'h0, 32'h0, 16'h041F, "R11");
      // R11 write enable low
      step(0, 16'h0400, 32'h5555_5555, 16'h0400, "R11");
      step(0, 16'h0011, 32'h0000_0001, 16'h0011, "R11");
      // R3/R4/R5 command registers
      step(1, 16'h1801, 32'h0000_1000, 16'h1801, "R4");
      step(1, 16'h1802, 32'h0000_2040, 16'h1802, "R3");
      step(1, 16'h1803, 32'h0000_3080, 16'h1803, "R5");
      step(1, 16'h1804, 32'h0000_40C0, 16'h1804, "R4");
      step(1, 16'h1805, 32'h0000_5100, 16'h1805, "R4");
      step(1, 16'h2001, 32'h0000_6140, 16'h2001, "R4");
      step(1, 16'h2002, 32'h0000_7180, 16'h2002, "R5");
      step(1, 16'h2003, 32'h0000_81C0, 16'h2003, "R4");
      step(0, 16'h0, 32'h0, 16'h1802, "R3");
      step(0, 16'h0, 32'h0, 16'h1803, "R5");
      // R6 fixed-one bit
      step(1, 16'h0011, 32'h0000_0000, 16'h0011, "R6");
      step(1, 16'h0011, 32'h0000_1234, 16'h0011, "R6");
      step(1, 16'h0011, 32'hFFFF_7FFF, 16'h0011, "R6");
      // R7 redirect, back to back
      step(1, 16'h0010, 32'h0000_0100, 16'h0010, "R7");
      step(1, 16'h0010, 32'hFFFF_FFFC, 16'h0010, "R7");
      step(0, 16'h0, 32'h0, 16'h0010, "R7");
      // R9 match entries
      step(1, 16'h0A03, 32'hFFFF_FFFF, 16'h0A03, "R9");
      step(1, 16'h1500, 32'h1234_5F5A, 16'h1500, "R9");
      step(1, 16'h0D0F, 32'hFFFF_FFFF, 16'h0D0F, "R9");
      // R10 translate entries
      step(1, 16'h0A83, 32'hFFFF_FFFF, 16'h0A83, "R10");
      step(1, 16'h1283, 32'hFFFF_FFFF, 16'h1283, "R10");
      step(1, 16'h1585, 32'hABCD_F7FF, 16'h1585, "R10");
      step(0, 16'h0, 32'h0, 16'h0A03, "R10");
      // R11 TLB set beyond count and unused way
      step(1, 16'h0A10, 32'hFFFF_FFFF, 16'h0A10, "R11");
      step(1, 16'h0E00, 32'hFFFF_FFFF, 16'h0E00, "R11");
      step(1, 16'h7777, 32'hFFFF_FFFF, 16'h7777, "R11");
      step(0, 16'h0, 32'h0, 16'h0A00, "R11");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule